// File: doc/BRIEF.md
# TDM Slot Audio Transmitter

This block is the sending half of a serial audio port that works on a time-division multiplexed link. A frame begins with a short frame-sync pulse and carries four slots of either 8 or 16 bits. The block shifts a word out, most significant bit first, only in the slots that configuration assigns to it. In every other slot, and in the idle bits after the last slot, its output-enable is low so that other transmitters can share the line.

Each assigned slot takes its word from one of two sources. In holding mode there is one holding register per slot, and each raises a request while it is empty. In FIFO mode the block pops an external show-ahead FIFO once per assigned slot. When the source has no fresh word at the start of a slot, the block sends a previous word again instead of stalling. In holding mode that is the word last sent in the same slot. In FIFO mode it is the last word popped, and a sticky underrun flag is set. Bit clock and frame sync are inputs. They are synchronised to the system clock, and data changes only after falling bit-clock edges.

Top module: `tdm_slot_tx`

## Requirements
- R1: `sd_oe` is 1 only while a slot whose bit in `cfg_slot_en` is 1 is being sent. It is 0 in unassigned slots, before the first frame and in the idle bits after slot 3.
- R2: When `fsync` is high at a rising `bclk` edge, bit 0 of slot 0 is driven after the next falling edge. Slots 0 to 3 then follow back to back, one bit per falling edge, and the line goes idle until the next sync.
- R3: Words go out most significant bit first. With `cfg_wide`=1 a slot holds 16 bits. With `cfg_wide`=0 a slot holds 8 bits, taken from bits 7:0 of the word.
- R4: In holding mode (`cfg_fifo_mode`=0), a one-cycle `hold_wr` with `hold_sel`=n fills holding register n. Bit n of `hold_req` is 1 while that register is empty. At the start of assigned slot n the register is sent and emptied. A holding register for an unassigned slot stays full.
- R5: If holding register n is empty at the start of assigned slot n, the word sent last in slot n is sent again. That word is 0 after reset.
- R6: In FIFO mode, each assigned slot with `fifo_empty`=0 pops one entry: `fifo_rd` is high for one clock while `fifo_rdata` shows the head. Consecutive assigned slots therefore send consecutive entries, and `tx_irq` pulses once, one clock after each pop.
- R7: In FIFO mode, if `fifo_empty`=1 at the start of an assigned slot, the last popped word is sent again, there is no pop and no `tx_irq`, and `tx_underrun` is set. The flag stays 1 until `und_clr` is high for a clock.
- R8: `sd_out` and `sd_oe` change only in the clock after a falling `bclk` edge has been detected. `fifo_rd` is never high in holding mode.
- R9: After reset, `sd_oe`=0, `hold_req`=4'b1111, `tx_underrun`=0 and `fifo_rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bclk | input | 1 | serial bit clock (asynchronous) |
| fsync | input | 1 | short frame-sync pulse |
| cfg_wide | input | 1 | 1: 16-bit slots, 0: 8-bit slots |
| cfg_fifo_mode | input | 1 | 1: FIFO source, 0: holding registers |
| cfg_slot_en | input | 4 | slot assignment, bit n = slot n |
| hold_wr | input | 1 | holding register write strobe |
| hold_sel | input | 2 | holding register index |
| hold_data | input | 16 | holding register write data |
| hold_req | output | 4 | bit n high while holding register n is empty |
| fifo_empty | input | 1 | external FIFO has no entry |
| fifo_rdata | input | 16 | head entry of the external FIFO |
| fifo_rd | output | 1 | pop strobe to the FIFO |
| und_clr | input | 1 | clears the underrun flag |
| tx_underrun | output | 1 | sticky FIFO underrun flag |
| tx_irq | output | 1 | one-clock pulse after each successful pop |
| sd_out | output | 1 | serial data |
| sd_oe | output | 1 | output enable for the serial data (0 means high impedance) |

## Verification
A slot or bit counter that is off by one shows at once in the first frame. The enable window moves by whole bits or slots, and received words come back rotated or land in the wrong slot. A wrong full flag or a stale copy of the last word shows in the next frame that finds an empty source: the resent word, or `hold_req`, differs from the expected value. A pop pointer or underrun fault shows within the frame that drains the FIFO. The signs are duplicated or skipped entries, a missing or extra `tx_irq`, or a flag that does not stick until it is cleared.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // frame tracking phase
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // source selection for a slot word
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_LAST  = 2'd1,
    SRC_FIFO  = 2'd2,
    SRC_FLAST = 2'd3
  } src_t;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic fall_tick,
  output logic rise_tick,
  output logic fs_s
);
  logic [STAGES-1:0] bc_sh_q, bc_sh_d;
  logic [STAGES-1:0] fs_sh_q, fs_sh_d;
  logic              bc_prev_q, bc_prev_d;

  always_comb begin
    bc_sh_d   = {bc_sh_q[STAGES-2:0], bclk};
    fs_sh_d   = {fs_sh_q[STAGES-2:0], fsync};
    bc_prev_d = bc_sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_sh_q   <= '0;
      fs_sh_q   <= '0;
      bc_prev_q <= 1'b0;
    end else begin
      bc_sh_q   <= bc_sh_d;
      fs_sh_q   <= fs_sh_d;
      bc_prev_q <= bc_prev_d;
    end
  end

  assign fall_tick = bc_prev_q & ~bc_sh_q[STAGES-1];
  assign rise_tick = ~bc_prev_q & bc_sh_q[STAGES-1];
  assign fs_s      = fs_sh_q[STAGES-1];
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_tx_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned WMAX   = 16,
  localparam int unsigned SW    = $clog2(NSLOTS),
  localparam int unsigned BW    = $clog2(WMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_tick,
  input  logic          rise_tick,
  input  logic          fs_s,
  input  logic          cfg_wide,
  output logic          active,
  output logic [SW-1:0] cur_slot,
  output logic          slot_start,
  output logic [SW-1:0] slot_nxt,
  output logic          shift_now,
  output logic          stop_now
);
  phase_t        ph_q, ph_d;
  logic          armed_q, armed_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [BW-1:0] last_bit;
  logic          start_now, end_of_slot, final_slot, next_slot_now;

  always_comb begin
    last_bit      = cfg_wide ? BW'(WMAX - 1) : BW'(WMAX / 2 - 1);
    start_now     = fall_tick & armed_q;
    end_of_slot   = (ph_q == PH_RUN) & (bit_q == last_bit);
    final_slot    = (slot_q == SW'(NSLOTS - 1));
    next_slot_now = fall_tick & ~armed_q & end_of_slot & ~final_slot;
    stop_now      = fall_tick & ~armed_q & end_of_slot & final_slot;
    shift_now     = fall_tick & ~armed_q & (ph_q == PH_RUN) & ~end_of_slot;
    slot_start    = start_now | next_slot_now;
    slot_nxt      = start_now ? '0 : slot_q + SW'(1);

    armed_d = armed_q;
    if (rise_tick && fs_s) armed_d = 1'b1;
    else if (fall_tick)    armed_d = 1'b0;

    ph_d   = ph_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (slot_start) begin
      ph_d   = PH_RUN;
      slot_d = slot_nxt;
      bit_d  = '0;
    end else if (stop_now) begin
      ph_d   = PH_IDLE;
    end else if (shift_now) begin
      bit_d  = bit_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      armed_q <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      armed_q <= armed_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
    end
  end

  assign active   = (ph_q == PH_RUN);
  assign cur_slot = slot_q;
endmodule

// File: rtl/tdm_word_src.sv
module tdm_word_src
  import tdm_tx_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned WMAX   = 16,
  localparam int unsigned SW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fifo_mode,
  input  logic              fetch,
  input  logic [SW-1:0]     fetch_slot,
  input  logic              hold_wr,
  input  logic [SW-1:0]     hold_sel,
  input  logic [WMAX-1:0]   hold_data,
  input  logic              fifo_empty,
  input  logic [WMAX-1:0]   fifo_rdata,
  input  logic              und_clr,
  output logic [WMAX-1:0]   word,
  output logic [NSLOTS-1:0] hold_req,
  output logic              fifo_rd,
  output logic              tx_irq,
  output logic              tx_underrun
);
  logic [WMAX-1:0]   hold_q [NSLOTS];
  logic [WMAX-1:0]   last_q [NSLOTS];
  logic [NSLOTS-1:0] full_q;
  logic [WMAX-1:0]   flast_q, flast_d;
  logic              irq_q, irq_d;
  logic              und_q, und_d;
  logic              fifo_miss;
  src_t              src;

  always_comb begin
    if (cfg_fifo_mode) src = fifo_empty ? SRC_FLAST : SRC_FIFO;
    else               src = full_q[fetch_slot] ? SRC_HOLD : SRC_LAST;
    case (src)
      SRC_HOLD:  word = hold_q[fetch_slot];
      SRC_LAST:  word = last_q[fetch_slot];
      SRC_FIFO:  word = fifo_rdata;
      default:   word = flast_q;
    endcase
    fifo_rd   = fetch & (src == SRC_FIFO);
    fifo_miss = fetch & (src == SRC_FLAST);
    flast_d   = fifo_rd ? fifo_rdata : flast_q;
    irq_d     = fifo_rd;
    und_d     = fifo_miss ? 1'b1 : (und_clr ? 1'b0 : und_q);
  end

  for (genvar n = 0; n < NSLOTS; n++) begin : g_slot
    logic            wr_n, take_n, full_d;
    logic [WMAX-1:0] hold_d, last_d;
    always_comb begin
      wr_n   = hold_wr & (hold_sel == SW'(n));
      take_n = fetch & ~cfg_fifo_mode & (fetch_slot == SW'(n)) & full_q[n];
      full_d = wr_n | (full_q[n] & ~take_n);
      hold_d = wr_n ? hold_data : hold_q[n];
      last_d = take_n ? hold_q[n] : last_q[n];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q[n] <= 1'b0;
        hold_q[n] <= '0;
        last_q[n] <= '0;
      end else begin
        full_q[n] <= full_d;
        hold_q[n] <= hold_d;
        last_q[n] <= last_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flast_q <= '0;
      irq_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      flast_q <= flast_d;
      irq_q   <= irq_d;
      und_q   <= und_d;
    end
  end

  assign hold_req    = ~full_q;
  assign tx_irq      = irq_q;
  assign tx_underrun = und_q;
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned WMAX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wide,
  input  logic            load,
  input  logic            load_en,
  input  logic            shift,
  input  logic            stop,
  input  logic [WMAX-1:0] word,
  output logic            sd_out,
  output logic            sd_oe
);
  localparam int unsigned NARROW = WMAX / 2;

  logic [WMAX-1:0] sh_q, sh_d;
  logic            out_q, out_d;
  logic            oe_q, oe_d;

  always_comb begin
    sh_d  = sh_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (load) begin
      sh_d = load_en ? word : '0;
      oe_d = load_en;
    end else if (shift) begin
      sh_d = {sh_q[WMAX-2:0], 1'b0};
    end else if (stop) begin
      oe_d = 1'b0;
    end
    if (load || shift || stop)
      out_d = oe_d & (cfg_wide ? sh_d[WMAX-1] : sh_d[NARROW-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign sd_out = out_q;
  assign sd_oe  = oe_q;
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int unsigned NSLOTS      = 4,
  parameter int unsigned WMAX        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SW         = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              cfg_wide,
  input  logic              cfg_fifo_mode,
  input  logic [NSLOTS-1:0] cfg_slot_en,
  input  logic              hold_wr,
  input  logic [SW-1:0]     hold_sel,
  input  logic [WMAX-1:0]   hold_data,
  output logic [NSLOTS-1:0] hold_req,
  input  logic              fifo_empty,
  input  logic [WMAX-1:0]   fifo_rdata,
  output logic              fifo_rd,
  input  logic              und_clr,
  output logic              tx_underrun,
  output logic              tx_irq,
  output logic              sd_out,
  output logic              sd_oe
);
  logic            rst_s1_q, rst_s2_q, rst_ns;
  logic            fall_tick, rise_tick, fs_s;
  logic            active, slot_start, shift_now, stop_now;
  logic [SW-1:0]   cur_slot, slot_nxt;
  logic            fetch;
  logic [WMAX-1:0] word;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ns = rst_s2_q;

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .bclk(bclk), .fsync(fsync),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .fs_s(fs_s)
  );

  tdm_frame_ctr #(.NSLOTS(NSLOTS), .WMAX(WMAX)) u_frame (
    .clk(clk), .rst_n(rst_ns), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .fs_s(fs_s), .cfg_wide(cfg_wide), .active(active), .cur_slot(cur_slot),
    .slot_start(slot_start), .slot_nxt(slot_nxt), .shift_now(shift_now),
    .stop_now(stop_now)
  );

  assign fetch = slot_start & cfg_slot_en[slot_nxt];

  tdm_word_src #(.NSLOTS(NSLOTS), .WMAX(WMAX)) u_src (
    .clk(clk), .rst_n(rst_ns), .cfg_fifo_mode(cfg_fifo_mode), .fetch(fetch),
    .fetch_slot(slot_nxt), .hold_wr(hold_wr), .hold_sel(hold_sel),
    .hold_data(hold_data), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .und_clr(und_clr), .word(word), .hold_req(hold_req), .fifo_rd(fifo_rd),
    .tx_irq(tx_irq), .tx_underrun(tx_underrun)
  );

  tdm_shifter #(.WMAX(WMAX)) u_shift (
    .clk(clk), .rst_n(rst_ns), .cfg_wide(cfg_wide), .load(slot_start),
    .load_en(fetch), .shift(shift_now), .stop(stop_now), .word(word),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
  parameter int unsigned NSLOTS = 4,
  localparam int unsigned SW    = $clog2(NSLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fall_tick,
  input logic              active,
  input logic [SW-1:0]     cur_slot,
  input logic [NSLOTS-1:0] cfg_slot_en,
  input logic              cfg_fifo_mode,
  input logic              fifo_empty,
  input logic              fifo_rd,
  input logic              und_clr,
  input logic              tx_underrun,
  input logic              tx_irq,
  input logic              sd_out,
  input logic              sd_oe
);
  a_r1_oe_in_assigned: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (active && cfg_slot_en[cur_slot]));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sd_oe);

  a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> ($stable(sd_out) && $stable(sd_oe)));

  a_r8_no_pop_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_mode |-> !fifo_rd);

  a_r6_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  a_r6_irq_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(fifo_rd));

  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun && !und_clr) |=> tx_underrun);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rst_n(rst_ns), .fall_tick(fall_tick), .active(active),
  .cur_slot(cur_slot), .cfg_slot_en(cfg_slot_en), .cfg_fifo_mode(cfg_fifo_mode),
  .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .und_clr(und_clr),
  .tx_underrun(tx_underrun), .tx_irq(tx_irq), .sd_out(sd_out), .sd_oe(sd_oe)
);

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 4;
  localparam int GAP_BITS   = 3;

  logic        clk, rst_n, bclk, fsync;
  logic        cfg_wide, cfg_fifo_mode;
  logic [3:0]  cfg_slot_en;
  logic        hold_wr;
  logic [1:0]  hold_sel;
  logic [15:0] hold_data;
  logic [3:0]  hold_req;
  logic        fifo_empty, fifo_rd, und_clr, tx_underrun, tx_irq;
  logic [15:0] fifo_rdata;
  logic        sd_out, sd_oe;

  tdm_slot_tx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_wide(cfg_wide), .cfg_fifo_mode(cfg_fifo_mode), .cfg_slot_en(cfg_slot_en),
    .hold_wr(hold_wr), .hold_sel(hold_sel), .hold_data(hold_data),
    .hold_req(hold_req), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .und_clr(und_clr), .tx_underrun(tx_underrun),
    .tx_irq(tx_irq), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;

  typedef struct { logic oe; logic [15:0] w; } exp_t;
  exp_t exp_q[$];

  // FIFO model (show-ahead)
  logic [15:0] fmem [32];
  int frp = 0;
  int fwp = 0;
  assign fifo_empty = (frp == fwp);
  assign fifo_rdata = fmem[frp[4:0]];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    bclk = 1'b0;
    forever begin
      repeat (HB) @(negedge clk);
      bclk = ~bclk;
    end
  end

  always @(posedge clk) begin
    if (fifo_rd && !fifo_empty) frp <= frp + 1;
    if (tx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic oe, input logic [15:0] w);
    exp_t e;
    e.oe = oe;
    e.w  = w;
    exp_q.push_back(e);
  endtask

  task automatic hold_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    hold_wr = 1'b1; hold_sel = sel; hold_data = d;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  task automatic fifo_push(input logic [15:0] d);
    @(negedge clk);
    fmem[fwp[4:0]] = d;
    fwp = fwp + 1;
  endtask

  // drives one frame and acts as the receiving monitor
  task automatic run_frame(input int w, input string tag);
    exp_t e;
    logic [15:0] word;
    logic oe_all, oe_any;
    @(negedge bclk); fsync = 1'b1;
    @(negedge bclk); fsync = 1'b0;
    for (int s = 0; s < 4; s++) begin
      word = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int b = 0; b < w; b++) begin
        @(posedge bclk); #1;
        oe_all = oe_all & sd_oe;
        oe_any = oe_any | sd_oe;
        word   = {word[14:0], sd_out};
      end
      e = exp_q.pop_front();
      if (e.oe) begin
        chk(oe_all, {tag, " R1 oe in assigned slot"}, 32'(oe_all), 32'd1);
        if (w == 8)
          chk(word[7:0] == e.w[7:0], {tag, " R3 narrow word"}, 32'(word[7:0]), 32'(e.w[7:0]));
        else
          chk(word == e.w, {tag, " R3 word"}, 32'(word), 32'(e.w));
      end else begin
        chk(!oe_any, {tag, " R1 oe low in unassigned slot"}, 32'(oe_any), 32'd0);
      end
    end
    for (int g = 0; g < GAP_BITS; g++) begin
      @(posedge bclk); #1;
      chk(!sd_oe, {tag, " R2 idle after last slot"}, 32'(sd_oe), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int irq0;
    rst_n = 1'b0; fsync = 1'b0; cfg_wide = 1'b1; cfg_fifo_mode = 1'b0;
    cfg_slot_en = 4'b1111; hold_wr = 1'b0; hold_sel = '0; hold_data = '0;
    und_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R9 reset state
    chk(sd_oe == 1'b0, "R9 oe after reset", 32'(sd_oe), 32'd0);
    chk(hold_req == 4'b1111, "R9 hold_req after reset", 32'(hold_req), 32'hf);
    chk(tx_underrun == 1'b0, "R9 underrun after reset", 32'(tx_underrun), 32'd0);
    chk(fifo_rd == 1'b0, "R9 fifo_rd after reset", 32'(fifo_rd), 32'd0);
    repeat (3 * 2 * HB) @(negedge clk);
    chk(sd_oe == 1'b0, "R1 oe before first frame", 32'(sd_oe), 32'd0);

    // R4 all slots from holding registers
    hold_write(2'd0, 16'hA5C3);
    hold_write(2'd1, 16'h1234);
    hold_write(2'd2, 16'hF00F);
    hold_write(2'd3, 16'h8001);
    chk(hold_req == 4'b0000, "R4 requests clear when full", 32'(hold_req), 32'h0);
    push_exp(1, 16'hA5C3); push_exp(1, 16'h1234);
    push_exp(1, 16'hF00F); push_exp(1, 16'h8001);
    run_frame(16, "R2 frame1");
    chk(hold_req == 4'b1111, "R4 requests after frame1", 32'(hold_req), 32'hf);

    // R1 partial assignment, R4 unassigned register stays full
    cfg_slot_en = 4'b0101;
    hold_write(2'd0, 16'h5AA5);
    hold_write(2'd1, 16'h0FF0);
    hold_write(2'd2, 16'hC33C);
    chk(hold_req == 4'b1000, "R4 requests before frame2", 32'(hold_req), 32'h8);
    push_exp(1, 16'h5AA5); push_exp(0, 16'h0);
    push_exp(1, 16'hC33C); push_exp(0, 16'h0);
    run_frame(16, "R1 frame2");
    chk(hold_req == 4'b1101, "R4 unassigned slot1 stays full", 32'(hold_req), 32'hd);

    // R5 retransmission of per-slot previous words
    cfg_slot_en = 4'b1111;
    push_exp(1, 16'h5AA5); push_exp(1, 16'h0FF0);
    push_exp(1, 16'hC33C); push_exp(1, 16'h8001);
    run_frame(16, "R5 frame3");
    chk(hold_req == 4'b1111, "R4 requests after frame3", 32'(hold_req), 32'hf);

    // R3 narrow words use the low byte
    cfg_wide = 1'b0;
    hold_write(2'd0, 16'hEE12);
    hold_write(2'd1, 16'hDD34);
    hold_write(2'd2, 16'hCC56);
    hold_write(2'd3, 16'hBB78);
    push_exp(1, 16'h0012); push_exp(1, 16'h0034);
    push_exp(1, 16'h0056); push_exp(1, 16'h0078);
    run_frame(8, "R3 frame4");

    // R6 FIFO mode, consecutive entries
    cfg_wide = 1'b1; cfg_fifo_mode = 1'b1;
    irq0 = irq_cnt;
    fifo_push(16'h1357); fifo_push(16'h2468);
    fifo_push(16'h369C); fifo_push(16'h48D1);
    push_exp(1, 16'h1357); push_exp(1, 16'h2468);
    push_exp(1, 16'h369C); push_exp(1, 16'h48D1);
    run_frame(16, "R6 frame5");
    chk(irq_cnt - irq0 == 4, "R6 irq per pop", 32'(irq_cnt - irq0), 32'd4);
    chk(tx_underrun == 1'b0, "R6 no underrun", 32'(tx_underrun), 32'd0);

    // R7 underrun: last popped word repeats
    irq0 = irq_cnt;
    fifo_push(16'h2468); fifo_push(16'h9BDF);
    push_exp(1, 16'h2468); push_exp(1, 16'h9BDF);
    push_exp(1, 16'h9BDF); push_exp(1, 16'h9BDF);
    run_frame(16, "R7 frame6");
    chk(irq_cnt - irq0 == 2, "R7 no irq on underrun", 32'(irq_cnt - irq0), 32'd2);
    chk(tx_underrun == 1'b1, "R7 underrun set", 32'(tx_underrun), 32'd1);
    repeat (20) @(negedge clk);
    chk(tx_underrun == 1'b1, "R7 underrun sticky", 32'(tx_underrun), 32'd1);
    und_clr = 1'b1; @(negedge clk); und_clr = 1'b0;
    @(negedge clk);
    chk(tx_underrun == 1'b0, "R7 underrun cleared", 32'(tx_underrun), 32'd0);

    // R6 partial assignment pops only for assigned slots
    cfg_slot_en = 4'b1010;
    irq0 = irq_cnt;
    fifo_push(16'h7E81); fifo_push(16'h6C39);
    push_exp(0, 16'h0); push_exp(1, 16'h7E81);
    push_exp(0, 16'h0); push_exp(1, 16'h6C39);
    run_frame(16, "R6 frame7");
    chk(irq_cnt - irq0 == 2, "R6 irq for assigned slots", 32'(irq_cnt - irq0), 32'd2);
    chk(fifo_empty == 1'b1, "R6 FIFO drained", 32'(fifo_empty), 32'd1);
    chk(tx_underrun == 1'b0, "R7 no underrun frame7", 32'(tx_underrun), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule